// File: doc/BRIEF.md
# Flush-to-Zero Single-Precision Multiplier

This block multiplies two IEEE-754 single-precision operands in a three-stage pipeline inside a processor datapath. It accepts one operation per cycle. Each operation carries a guard bit and a two-bit rounding mode. The block returns the rounded product together with a write-enable and a six-bit exception vector. It does not handle subnormal numbers gradually. A subnormal operand is treated as zero and raises an input-flush indication. A result that would land in the subnormal range becomes zero and raises an output-flush indication.

A surrounding status register is expected to OR the exception vector into its sticky bits whenever the write-enable is high. The guard bit decides whether an operation commits. When it is low, nothing leaves the pipeline for that operation: no write-enable, no flags, and the result port keeps its previous value.

Top module: `ftzMul`

## Requirements
- R1: For two normal operands whose product is a normal number, `resVal` is the correctly rounded product (default mode 00, round to nearest with ties to even). The sign is the XOR of the operand signs, and the flag vector is clear when the product is exact.
- R2: `rndMode` selects rounding: 00 is nearest with ties to even, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity. The inexact flag (bit 0) is set whenever the rounding discards nonzero bits.
- R3: An operand with a zero exponent field and a nonzero fraction is treated as zero of its own sign, and the input-flush flag (bit 5) is set.
- R4: A product whose rounded exponent would fall in the subnormal range gives a signed zero. The range is a biased exponent from 0 down to -23, that is, a magnitude of at least 2^-150. Output-flush (bit 4), underflow (bit 1) and inexact (bit 0) are all set.
- R5: A product smaller in magnitude than 2^-150 gives a signed zero with underflow and inexact set and output-flush clear.
- R6: Infinity times zero, and any operation with a signaling-NaN operand, gives 0xFFFFFFFF with invalid (bit 3) set. A quiet-NaN operand gives 0xFFFFFFFF with no flag.
- R7: On overflow, overflow (bit 2) and inexact are set. The result is infinity in mode 00. In mode 01 it is the largest finite value. In mode 10 it is +infinity for a positive result and -max for a negative one. In mode 11 it is -infinity for a negative result and +max for a positive one.
- R8: Infinity times a nonzero non-NaN value gives a correctly signed infinity, and zero times a finite value gives a correctly signed zero. Neither raises a flag.
- R9: An operation issued with `guard` low never raises `resWe`, contributes no flags, and leaves `resVal` unchanged.
- R10: The result of an operation issued with `guard` high appears with `resWe` high exactly 3 cycles after issue. A new operation can be issued every cycle.
- R11: `excFlags` is all zero whenever `resWe` is low. When `resWe` is high its bits are {inFlush, outFlush, invalid, overflow, underflow, inexact} from bit 5 down to bit 0.
- R12: After reset `resWe`, `resVal` and `excFlags` are zero, and operations in flight when reset arrives are discarded.
- R13: A committed result never has a zero exponent field with a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Starts an operation this cycle |
| guard | input | 1 | Commit enable for the issued operation |
| rndMode | input | 2 | Rounding mode of the issued operation |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| resWe | output | 1 | Result write-enable, 3 cycles after a committed issue |
| resVal | output | 32 | Product, updated only when committed |
| excFlags | output | 6 | Exception indications, valid with resWe |

## Verification
The bound checker watches, on every cycle, the relations that hold regardless of the numbers involved. These are the three-cycle link from a guarded issue to `resWe`, silent flags and a held result while `resWe` is low, and the absence of subnormal outputs. They also include the flag couplings: overflow implies inexact, output-flush implies underflow, underflow implies a zero result, and invalid implies the all-ones NaN. The actual arithmetic can only be shown by the bench's scenarios. That covers rounding in each mode (including ties in both parities), the inclusive edge of the flush window at 2^-150, the choice between infinity and the largest finite value on overflow, and the special operand combinations.

// File: rtl/ftzMulPkg.sv
package ftzMulPkg;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
    logic outLoad;
  } pipeCtrl_t;

  typedef enum logic [1:0] {
    KIND_NORM = 2'b00,
    KIND_ZERO = 2'b01,
    KIND_INF  = 2'b10,
    KIND_NAN  = 2'b11
  } opKind_t;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rndMode_t;

  localparam int FLAG_W       = 6;
  localparam int FB_INFLUSH   = 5;
  localparam int FB_OUTFLUSH  = 4;
  localparam int FB_INVALID   = 3;
  localparam int FB_OVERFLOW  = 2;
  localparam int FB_UNDERFLOW = 1;
  localparam int FB_INEXACT   = 0;

endpackage

// File: rtl/ftzMulCtrl.sv
module ftzMulCtrl
  import ftzMulPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      issue,
  input  logic      guard,
  output pipeCtrl_t ctl,
  output logic      resWe
);

  logic v1Q, v2Q, weQ;

  // only guarded operations travel down the pipe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1Q <= 1'b0;
      v2Q <= 1'b0;
      weQ <= 1'b0;
    end else begin
      v1Q <= issue & guard;
      v2Q <= v1Q;
      weQ <= v2Q;
    end
  end

  always_comb begin
    ctl.s1Load  = issue & guard;
    ctl.s2Load  = v1Q;
    ctl.outLoad = v2Q;
  end

  assign resWe = weQ;

endmodule

// File: rtl/ftzMulRound.sv
module ftzMulRound
  import ftzMulPkg::*;
#(
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W-1:0] fracIn,
  input  logic              gBit,
  input  logic              sBit,
  input  logic              sign,
  input  rndMode_t          mode,
  output logic [FRAC_W-1:0] fracOut,
  output logic              carry,
  output logic              inexact
);

  logic inc;

  always_comb begin
    unique case (mode)
      RM_NEAR: inc = gBit & (sBit | fracIn[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~sign & (gBit | sBit);
      RM_DOWN: inc =  sign & (gBit | sBit);
      default: inc = 1'b0;
    endcase
  end

  // an all-ones fraction wraps to zero and bumps the exponent
  assign fracOut = fracIn + FRAC_W'(inc);
  assign carry   = (&fracIn) & inc;
  assign inexact = gBit | sBit;

endmodule

// File: rtl/ftzMulDp.sv
module ftzMulDp
  import ftzMulPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipeCtrl_t         ctl,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic [1:0]        rndMode,
  output logic [W-1:0]      resVal,
  output logic [FLAG_W-1:0] excFlags
);

  localparam int MAN_W    = FRAC_W + 1;
  localparam int PROD_W   = 2 * MAN_W;
  localparam int EW       = EXP_W + 2;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ALL1 = (1 << EXP_W) - 1;
  localparam logic signed [EW-1:0] EXP_TOP   = EW'(EXP_ALL1);
  localparam logic signed [EW-1:0] EXP_ZERO  = '0;
  localparam logic signed [EW-1:0] EXP_FLOOR = EW'(-FRAC_W);
  localparam logic signed [EW-1:0] BIAS_S    = EW'(BIAS);

  // ---------------- stage 1: classify and multiply ----------------
  logic [W-1:0]      opIn   [2];
  logic [EXP_W-1:0]  expF   [2];
  logic [FRAC_W-1:0] fracF  [2];
  logic              isZero [2];
  logic              isDen  [2];
  logic              isInf  [2];
  logic              isNan  [2];
  logic              isSnan [2];

  assign opIn[0] = opA;
  assign opIn[1] = opB;

  for (genvar g = 0; g < 2; g++) begin : gClass
    assign expF[g]   = opIn[g][W-2 -: EXP_W];
    assign fracF[g]  = opIn[g][FRAC_W-1:0];
    assign isZero[g] = (expF[g] == '0);
    assign isDen[g]  = (expF[g] == '0) & (|fracF[g]);
    assign isInf[g]  = (&expF[g]) & ~(|fracF[g]);
    assign isNan[g]  = (&expF[g]) &  (|fracF[g]);
    assign isSnan[g] = isNan[g] & ~fracF[g][FRAC_W-1];
  end

  opKind_t              kind1;
  logic                 inv1;
  logic                 sign1;
  logic signed [EW-1:0] expSum1;
  logic [PROD_W-1:0]    prod1;

  always_comb begin
    kind1 = KIND_NORM;
    inv1  = 1'b0;
    if (isNan[0] | isNan[1]) begin
      kind1 = KIND_NAN;
      inv1  = isSnan[0] | isSnan[1];
    end else if ((isInf[0] & isZero[1]) | (isInf[1] & isZero[0])) begin
      kind1 = KIND_NAN;
      inv1  = 1'b1;
    end else if (isInf[0] | isInf[1]) begin
      kind1 = KIND_INF;
    end else if (isZero[0] | isZero[1]) begin
      kind1 = KIND_ZERO;
    end
  end

  assign sign1   = opA[W-1] ^ opB[W-1];
  assign expSum1 = $signed({2'b00, expF[0]}) + $signed({2'b00, expF[1]}) - BIAS_S;
  assign prod1   = {1'b1, fracF[0]} * {1'b1, fracF[1]};

  opKind_t              s1Kind;
  logic                 s1Inv, s1Ifz, s1Sign;
  logic signed [EW-1:0] s1Exp;
  logic [PROD_W-1:0]    s1Prod;
  rndMode_t             s1Mode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Kind <= KIND_ZERO;
      s1Inv  <= 1'b0;
      s1Ifz  <= 1'b0;
      s1Sign <= 1'b0;
      s1Exp  <= '0;
      s1Prod <= '0;
      s1Mode <= RM_NEAR;
    end else if (ctl.s1Load) begin
      s1Kind <= kind1;
      s1Inv  <= inv1;
      s1Ifz  <= isDen[0] | isDen[1];
      s1Sign <= sign1;
      s1Exp  <= expSum1;
      s1Prod <= prod1;
      s1Mode <= rndMode_t'(rndMode);
    end
  end

  // ---------------- stage 2: normalise, round, pack ----------------
  logic                 hi;
  logic [FRAC_W-1:0]    fracN;
  logic [MAN_W-1:0]     restN;
  logic signed [EW-1:0] expN, expR;
  logic [FRAC_W-1:0]    fracR;
  logic                 carryR, inexactR;

  assign hi    = s1Prod[PROD_W-1];
  assign fracN = hi ? s1Prod[PROD_W-2 -: FRAC_W] : s1Prod[PROD_W-3 -: FRAC_W];
  assign restN = hi ? s1Prod[MAN_W-1:0] : {s1Prod[MAN_W-2:0], 1'b0};
  assign expN  = s1Exp + $signed(EW'(hi));

  ftzMulRound #(.FRAC_W(FRAC_W)) uRound (
    .fracIn  (fracN),
    .gBit    (restN[MAN_W-1]),
    .sBit    (|restN[MAN_W-2:0]),
    .sign    (s1Sign),
    .mode    (s1Mode),
    .fracOut (fracR),
    .carry   (carryR),
    .inexact (inexactR)
  );

  assign expR = expN + $signed(EW'(carryR));

  logic [W-1:0]      val2;
  logic [FLAG_W-1:0] flags2;
  logic              toInf;

  always_comb begin
    toInf = (s1Mode == RM_NEAR) | ((s1Mode == RM_UP) & ~s1Sign) |
            ((s1Mode == RM_DOWN) & s1Sign);
    val2   = '0;
    flags2 = '0;
    unique case (s1Kind)
      KIND_NAN:  val2 = '1;
      KIND_INF:  val2 = {s1Sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      KIND_ZERO: val2 = {s1Sign, {(W-1){1'b0}}};
      default: begin
        if (expR >= EXP_TOP) begin
          flags2[FB_OVERFLOW] = 1'b1;
          flags2[FB_INEXACT]  = 1'b1;
          val2 = toInf ? {s1Sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                       : {s1Sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else if (expR <= EXP_ZERO) begin
          flags2[FB_UNDERFLOW] = 1'b1;
          flags2[FB_INEXACT]   = 1'b1;
          flags2[FB_OUTFLUSH]  = (expR >= EXP_FLOOR);
          val2 = {s1Sign, {(W-1){1'b0}}};
        end else begin
          flags2[FB_INEXACT] = inexactR;
          val2 = {s1Sign, expR[EXP_W-1:0], fracR};
        end
      end
    endcase
    flags2[FB_INFLUSH] = s1Ifz;
    flags2[FB_INVALID] = s1Inv;
  end

  logic [W-1:0]      s2Val;
  logic [FLAG_W-1:0] s2Flags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Val   <= '0;
      s2Flags <= '0;
    end else if (ctl.s2Load) begin
      s2Val   <= val2;
      s2Flags <= flags2;
    end
  end

  // ---------------- stage 3: commit ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resVal   <= '0;
      excFlags <= '0;
    end else begin
      if (ctl.outLoad) resVal <= s2Val;
      excFlags <= ctl.outLoad ? s2Flags : '0;
    end
  end

endmodule

// File: rtl/ftzMul.sv
module ftzMul
  import ftzMulPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       issue,
  input  logic                       guard,
  input  logic [1:0]                 rndMode,
  input  logic [EXP_W+FRAC_W:0]      opA,
  input  logic [EXP_W+FRAC_W:0]      opB,
  output logic                       resWe,
  output logic [EXP_W+FRAC_W:0]      resVal,
  output logic [FLAG_W-1:0]          excFlags
);

  pipeCtrl_t ctl;

  ftzMulCtrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .issue (issue),
    .guard (guard),
    .ctl   (ctl),
    .resWe (resWe)
  );

  ftzMulDp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .rndMode  (rndMode),
    .resVal   (resVal),
    .excFlags (excFlags)
  );

endmodule

// File: rtl/ftzMulChk.sv
module ftzMulChk
  import ftzMulPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              issue,
  input logic              guard,
  input logic              resWe,
  input logic [W-1:0]      resVal,
  input logic [FLAG_W-1:0] excFlags
);

  logic [1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  AST_COMMIT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) |-> (resWe == $past(issue && guard, 3))); // R10

  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !resWe |-> (excFlags == '0)); // R11

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    ((upCnt != 2'd0) && !resWe) |-> $stable(resVal)); // R9

  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && excFlags[FB_OVERFLOW]) |-> excFlags[FB_INEXACT]); // R7

  AST_OUTFLUSH_UNF: assert property (@(posedge clk) disable iff (!rstN)
    excFlags[FB_OUTFLUSH] |-> (excFlags[FB_UNDERFLOW] && excFlags[FB_INEXACT])); // R4

  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && excFlags[FB_UNDERFLOW]) |-> (resVal[W-2:0] == '0)); // R5

  AST_INVALID_NAN: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && excFlags[FB_INVALID]) |-> (resVal == '1)); // R6

  AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rstN)
    resWe |-> !((resVal[W-2 -: EXP_W] == '0) && (resVal[FRAC_W-1:0] != '0))); // R13

endmodule

bind ftzMul ftzMulChk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .issue    (issue),
  .guard    (guard),
  .resWe    (resWe),
  .resVal   (resVal),
  .excFlags (excFlags)
);

// File: tb/sim_ftzMul.sv
module sim_ftzMul;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic        guard = 1'b0;
  logic [1:0]  rndMode = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        resWe;
  logic [31:0] resVal;
  logic [5:0]  excFlags;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ftzMul u0 (
    .clk(clk), .rstN(rstN), .issue(issue), .guard(guard), .rndMode(rndMode),
    .opA(opA), .opB(opB), .resWe(resWe), .resVal(resVal), .excFlags(excFlags)
  );

  // {req[3:0], mode[1:0], a, b, expected value, expected flags}
  // flags: {inFlush, outFlush, invalid, overflow, underflow, inexact}
  localparam int NV = 28;
  localparam logic [107:0] VEC [NV] = '{
    {4'd1, 2'b00, 32'hC0400000, 32'h3F800000, 32'hC0400000, 6'h00}, // R1
    {4'd1, 2'b00, 32'h40400000, 32'hC0400000, 32'hC1100000, 6'h00}, // R1
    {4'd1, 2'b00, 32'h40400000, 32'h00800000, 32'h01400000, 6'h00}, // R1
    {4'd2, 2'b00, 32'h3FC00000, 32'h3F800001, 32'h3FC00002, 6'h01}, // R2 tie, odd -> up
    {4'd2, 2'b00, 32'h3FC00000, 32'h3F800003, 32'h3FC00004, 6'h01}, // R2 tie, even kept
    {4'd2, 2'b01, 32'h3FC00000, 32'h3F800001, 32'h3FC00001, 6'h01}, // R2 toward zero
    {4'd2, 2'b10, 32'h3F800001, 32'h3F800001, 32'h3F800003, 6'h01}, // R2 up, positive
    {4'd2, 2'b11, 32'h3F800001, 32'h3F800001, 32'h3F800002, 6'h01}, // R2 down, positive
    {4'd2, 2'b10, 32'hBF800001, 32'h3F800001, 32'hBF800002, 6'h01}, // R2 up, negative
    {4'd2, 2'b11, 32'hBF800001, 32'h3F800001, 32'hBF800003, 6'h01}, // R2 down, negative
    {4'd3, 2'b00, 32'h40400000, 32'h00400000, 32'h00000000, 6'h20}, // R3
    {4'd3, 2'b00, 32'h00000001, 32'h80000003, 32'h80000000, 6'h20}, // R3 signed zero
    {4'd4, 2'b00, 32'h3F000000, 32'h00800000, 32'h00000000, 6'h13}, // R4
    {4'd4, 2'b00, 32'h00800000, 32'h33800000, 32'h00000000, 6'h13}, // R4 edge 2^-150
    {4'd5, 2'b00, 32'h00800000, 32'h33000000, 32'h00000000, 6'h03}, // R5 just below
    {4'd5, 2'b00, 32'h00800000, 32'h00800000, 32'h00000000, 6'h03}, // R5
    {4'd6, 2'b00, 32'h7F800000, 32'h00000000, 32'hFFFFFFFF, 6'h08}, // R6
    {4'd6, 2'b00, 32'h7F800001, 32'h3F800000, 32'hFFFFFFFF, 6'h08}, // R6 signaling
    {4'd6, 2'b00, 32'h7FC00000, 32'h40400000, 32'hFFFFFFFF, 6'h00}, // R6 quiet
    {4'd6, 2'b00, 32'h7F800000, 32'h00000001, 32'hFFFFFFFF, 6'h28}, // R6 with R3
    {4'd7, 2'b00, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 6'h05}, // R7
    {4'd7, 2'b01, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF, 6'h05}, // R7
    {4'd7, 2'b11, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF, 6'h05}, // R7
    {4'd7, 2'b10, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF7FFFFF, 6'h05}, // R7
    {4'd7, 2'b11, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF800000, 6'h05}, // R7
    {4'd8, 2'b00, 32'h7F800000, 32'hFF800000, 32'hFF800000, 6'h00}, // R8
    {4'd8, 2'b00, 32'h7F800000, 32'hC0400000, 32'hFF800000, 6'h00}, // R8
    {4'd8, 2'b00, 32'h80000000, 32'h40400000, 32'h80000000, 6'h00}  // R8
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic drive(input logic g, input logic [1:0] m, input logic [31:0] a,
                       input logic [31:0] b);
    issue = 1'b1; guard = g; rndMode = m; opA = a; opB = b;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(resWe == 1'b0, "R12 we", {31'd0, resWe}, 32'h0);
    chk(resVal == 32'h0, "R12 val", resVal, 32'h0);
    chk(excFlags == 6'h0, "R12 flags", {26'd0, excFlags}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table, issued back to back (R10 throughput), checked 3 cycles later
    for (int i = 0; i < NV + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        logic [107:0] v;
        string tag;
        v = VEC[i-3];
        tag = $sformatf("R%0d vec%0d", v[107:104], i - 3);
        chk(resWe == 1'b1, {tag, " R10 we"}, {31'd0, resWe}, 32'h1);
        chk(resVal == v[37:6], {tag, " val"}, resVal, v[37:6]);
        chk(excFlags == v[5:0], {tag, " flags"}, {26'd0, excFlags}, {26'd0, v[5:0]});
      end
      if (i < NV) drive(1'b1, VEC[i][103:102], VEC[i][101:70], VEC[i][69:38]);
      else issue = 1'b0;
    end
    @(negedge clk);
    chk(resWe == 1'b0, "R11 idle we", {31'd0, resWe}, 32'h0);
    chk(excFlags == 6'h0, "R11 idle flags", {26'd0, excFlags}, 32'h0);

    // R9: committed result, then an unguarded invalid op must leave no trace
    drive(1'b1, 2'b00, 32'h40400000, 32'hC0400000);
    @(negedge clk);
    drive(1'b0, 2'b00, 32'h7F800000, 32'h00000000);
    @(negedge clk);
    issue = 1'b0;
    @(negedge clk);
    chk(resWe == 1'b1 && resVal == 32'hC1100000, "R10 single", resVal, 32'hC1100000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(resWe == 1'b0, "R9 we", {31'd0, resWe}, 32'h0);
      chk(resVal == 32'hC1100000, "R9 val", resVal, 32'hC1100000);
      chk(excFlags == 6'h0, "R9 flags", {26'd0, excFlags}, 32'h0);
    end

    // R12: operation in flight is dropped by reset
    drive(1'b1, 2'b00, 32'h7F7FFFFF, 32'h7F7FFFFF);
    @(negedge clk);
    issue = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(resVal == 32'h0 && excFlags == 6'h0, "R12 mid reset", resVal, 32'h0);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(resWe == 1'b0, "R12 drop we", {31'd0, resWe}, 32'h0);
      chk(excFlags == 6'h0, "R12 drop flags", {26'd0, excFlags}, 32'h0);
    end

    finishRun();
  end

endmodule